// File: doc/BRIEF.md
# Parallel Flash Bus Front End

This block is the device-side pin decoder of a parallel NOR-style memory with an 8- or 16-bit data bus. Once per clock it registers the active-low chip enable, output enable, write enable and hardware reset pins, together with the width-select, write-protect, address and data pins. From these it works out which bus operation is in progress and reports it on a status output. Real tri-state pads are not used. The block drives a data-out vector and a per-lane output-enable vector, and a lane with its enable low is taken to be high-impedance.

A read drives a word from a small computed array that stands in for the storage. In word mode the full word goes out on all sixteen lanes. In byte mode only the low eight lanes are driven, and the top data pin acts as an extra low-order address bit that picks the low or high half of the word. A write is a command cycle. Address and data are held for as long as the write lasts and are handed to the downstream command state machine with a one-cycle strobe when write enable or chip enable rises. Writes to locked sectors are dropped. The per-sector lock is a plain input flag, and a low write-protect pin also locks the two lowest boot sectors.

Top module: `pflash_bus_front`

## Requirements
- R1: With chip enable low, output enable low, write enable high and the reset pin high, the block decodes a read and drives the array word at the current address. The array word at index i is {lo ^ 8'hC3, lo}, where lo = i[7:0] and the index is the low 8 address bits.
- R2: A write is chip enable low, output enable high, write enable low and the reset pin high. When write enable or chip enable next rises, cmd_valid pulses high for exactly one cycle. cmd_addr and cmd_data carry the last sampled write address and data. In word mode cmd_addr is {addr, 0}.
- R3: With the reset pin high and chip enable high, the block decodes standby and every lane enable is low.
- R4: With chip enable low and output enable and write enable both high, the block decodes output disable and no lane is driven. Chip enable, output enable and write enable all low is also output disable, with no read and no command.
- R5: A low reset pin overrides all other pins. It reports the reset operation and drives no lane. A write that is pending when it arrives is dropped without any strobe.
- R6: When word_sel is 1 (word mode), a read enables all sixteen lanes (dq_oe = 16'hFFFF).
- R7: When word_sel is 0 (byte mode), a read enables lanes 0 to 7 only (dq_oe = 16'h00FF), and the upper lanes of dq_out are 0. dq_in[15] is the low address bit: 0 selects word bits 7:0 and 1 selects bits 15:8. A byte-mode write reports cmd_addr = {addr, dq_in[15]} and cmd_data = {8'h00, dq_in[7:0]}.
- R8: After reset, reads return array data with no command issued first.
- R9: The sector is the top three bits of cmd_addr. When wprot_n is low, writes to sectors 0 and 1 give no strobe. When wprot_n is high, they are accepted unless the sector is locked.
- R10: When sect_lock[s] is 1, a write to sector s gives no strobe.
- R11: bus_op encodes standby=0, read=1, write=2, output disable=3, reset=4. bus_op, dq_out and dq_oe reflect the pins sampled two clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low register reset |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| hw_rst_n | input | 1 | Hardware reset pin, active low |
| word_sel | input | 1 | 1 selects word mode, 0 selects byte mode |
| wprot_n | input | 1 | Write-protect pin, active low |
| addr | input | 19 | Word address pins |
| dq_in | input | 16 | Data pins as seen by the input buffers |
| sect_lock | input | 8 | Per-sector lock flags |
| dq_out | output | 16 | Data-out value |
| dq_oe | output | 16 | Per-lane output enable |
| bus_op | output | 3 | Decoded bus operation |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_addr | output | 20 | Latched command address (byte granular) |
| cmd_data | output | 16 | Latched command data |

## Verification
The decoder is driven with random combinations of the five control pins, including reset-low patterns, in both widths. This checks that each truth-table row maps to one status code and one lane-enable pattern. Random addresses with both values of the low address bit separate the high byte from the low byte, and word data from byte data. Directed write cycles end by a rise of write enable in some cases and of chip enable in others. They are aimed at boot sectors with write-protect low and high, at a locked sector and at an unlocked one, so each rejection cause is told apart from correct acceptance. Further cases drop the reset pin mid-write and drive all three enables low, to show that no strobe is produced.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
    typedef enum logic [2:0] {
        OP_STANDBY = 3'd0,
        OP_READ    = 3'd1,
        OP_WRITE   = 3'd2,
        OP_OUTDIS  = 3'd3,
        OP_RESET   = 3'd4
    } bus_op_e;
endpackage

// File: rtl/pflash_op_decode.sv
module pflash_op_decode
    import pflash_pkg::*;
(
    input  logic    ce_n,
    input  logic    oe_n,
    input  logic    we_n,
    input  logic    hw_rst_n,
    output bus_op_e op
);
    // Reset pin first, then chip select, then the strobe pair.
    always_comb begin
        if (!hw_rst_n)           op = OP_RESET;
        else if (ce_n)           op = OP_STANDBY;
        else if (!oe_n && we_n)  op = OP_READ;
        else if (oe_n && !we_n)  op = OP_WRITE;
        else                     op = OP_OUTDIS;
    end
endmodule

// File: rtl/pflash_read_path.sv
module pflash_read_path
    import pflash_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DQ_W   = 16,
    parameter int DEPTH  = 256,
    parameter int HI_XOR = 'hC3
) (
    input  bus_op_e           op,
    input  logic              word_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic              a_lsb,
    output logic [DQ_W-1:0]   dout,
    output logic [DQ_W-1:0]   doe
);
    localparam int HALF  = DQ_W / 2;
    localparam int IDX_W = $clog2(DEPTH);

    // Computed stand-in storage.
    logic [DQ_W-1:0] rom [DEPTH];
    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
        assign rom[i] = {HALF'(i) ^ HALF'(HI_XOR), HALF'(i)};
    end

    logic [DQ_W-1:0] word;
    assign word = rom[addr[IDX_W-1:0]];

    always_comb begin
        dout = '0;
        doe  = '0;
        if (op == OP_READ) begin
            if (word_sel) begin
                dout = word;
                doe  = '1;
            end else begin
                dout = {{HALF{1'b0}}, (a_lsb ? word[DQ_W-1:HALF] : word[HALF-1:0])};
                doe  = {{HALF{1'b0}}, {HALF{1'b1}}};
            end
        end
    end
endmodule

// File: rtl/pflash_cmd_latch.sv
module pflash_cmd_latch
    import pflash_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DQ_W     = 16,
    parameter int NUM_SECT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  bus_op_e           op,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              hw_rst_n,
    input  logic              wprot_n,
    input  logic              word_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    input  logic [NUM_SECT-1:0] sect_lock,
    output logic              cmd_valid,
    output logic [ADDR_W:0]   cmd_addr,
    output logic [DQ_W-1:0]   cmd_data
);
    localparam int HALF   = DQ_W / 2;
    localparam int CA_W   = ADDR_W + 1;
    localparam int SECT_W = $clog2(NUM_SECT);

    typedef struct packed {
        logic            pend;
        logic            valid;
        logic [CA_W-1:0] addr;
        logic [DQ_W-1:0] data;
    } cmd_st_t;

    cmd_st_t st_d, st_q;
    logic [SECT_W-1:0] sect;
    logic              blocked;

    assign sect    = st_q.addr[CA_W-1 -: SECT_W];
    assign blocked = sect_lock[sect] || (!wprot_n && (sect < SECT_W'(2)));

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (op == OP_WRITE) begin
            st_d.pend = 1'b1;
            st_d.addr = word_sel ? {addr, 1'b0} : {addr, dq_in[DQ_W-1]};
            st_d.data = word_sel ? dq_in : {{HALF{1'b0}}, dq_in[HALF-1:0]};
        end else begin
            // A rising strobe ends the cycle; reset or other exits drop it.
            if (st_q.pend && hw_rst_n && (we_n || ce_n) && !blocked)
                st_d.valid = 1'b1;
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_valid = st_q.valid;
    assign cmd_addr  = st_q.addr;
    assign cmd_data  = st_q.data;
endmodule

// File: rtl/pflash_bus_front.sv
module pflash_bus_front
    import pflash_pkg::*;
#(
    parameter int ADDR_W   = 19,
    parameter int DQ_W     = 16,
    parameter int DEPTH    = 256,
    parameter int NUM_SECT = 8,
    parameter int HI_XOR   = 'hC3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ce_n,
    input  logic                oe_n,
    input  logic                we_n,
    input  logic                hw_rst_n,
    input  logic                word_sel,
    input  logic                wprot_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DQ_W-1:0]     dq_in,
    input  logic [NUM_SECT-1:0] sect_lock,
    output logic [DQ_W-1:0]     dq_out,
    output logic [DQ_W-1:0]     dq_oe,
    output logic [2:0]          bus_op,
    output logic                cmd_valid,
    output logic [ADDR_W:0]     cmd_addr,
    output logic [DQ_W-1:0]     cmd_data
);
    typedef struct packed {
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              rst_n;
        logic              word_sel;
        logic              wp_n;
        logic [ADDR_W-1:0] addr;
        logic [DQ_W-1:0]   dq;
    } pins_t;

    typedef struct packed {
        bus_op_e         op;
        logic [DQ_W-1:0] dout;
        logic [DQ_W-1:0] doe;
    } out_t;

    pins_t   pin_d, pin_q;
    out_t    out_d, out_q;
    bus_op_e op_w;
    logic [DQ_W-1:0] rd_dout, rd_doe;

    // Stage 1: pin capture
    always_comb begin
        pin_d.ce_n     = ce_n;
        pin_d.oe_n     = oe_n;
        pin_d.we_n     = we_n;
        pin_d.rst_n    = hw_rst_n;
        pin_d.word_sel = word_sel;
        pin_d.wp_n     = wprot_n;
        pin_d.addr     = addr;
        pin_d.dq       = dq_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_q          <= '0;
            pin_q.ce_n     <= 1'b1;
            pin_q.oe_n     <= 1'b1;
            pin_q.we_n     <= 1'b1;
            pin_q.rst_n    <= 1'b1;
            pin_q.word_sel <= 1'b1;
            pin_q.wp_n     <= 1'b1;
        end else begin
            pin_q <= pin_d;
        end
    end

    pflash_op_decode u_dec (
        .ce_n     (pin_q.ce_n),
        .oe_n     (pin_q.oe_n),
        .we_n     (pin_q.we_n),
        .hw_rst_n (pin_q.rst_n),
        .op       (op_w)
    );

    pflash_read_path #(
        .ADDR_W (ADDR_W),
        .DQ_W   (DQ_W),
        .DEPTH  (DEPTH),
        .HI_XOR (HI_XOR)
    ) u_rd (
        .op       (op_w),
        .word_sel (pin_q.word_sel),
        .addr     (pin_q.addr),
        .a_lsb    (pin_q.dq[DQ_W-1]),
        .dout     (rd_dout),
        .doe      (rd_doe)
    );

    pflash_cmd_latch #(
        .ADDR_W   (ADDR_W),
        .DQ_W     (DQ_W),
        .NUM_SECT (NUM_SECT)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op_w),
        .ce_n      (pin_q.ce_n),
        .we_n      (pin_q.we_n),
        .hw_rst_n  (pin_q.rst_n),
        .wprot_n   (pin_q.wp_n),
        .word_sel  (pin_q.word_sel),
        .addr      (pin_q.addr),
        .dq_in     (pin_q.dq),
        .sect_lock (sect_lock),
        .cmd_valid (cmd_valid),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data)
    );

    // Stage 2: output register
    always_comb begin
        out_d.op   = op_w;
        out_d.dout = rd_dout;
        out_d.doe  = rd_doe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.op   <= OP_STANDBY;
            out_q.dout <= '0;
            out_q.doe  <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign bus_op = out_q.op;
    assign dq_out = out_q.dout;
    assign dq_oe  = out_q.doe;
endmodule

// File: rtl/pflash_bus_front_chk.sv
module pflash_bus_front_chk #(
    parameter int DQ_W = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hw_rst_n,
    input logic [DQ_W-1:0] dq_oe,
    input logic [2:0]      bus_op,
    input logic            cmd_valid
);
    localparam logic [DQ_W-1:0] LOW_LANES = {{(DQ_W/2){1'b0}}, {(DQ_W/2){1'b1}}};

    // R3 R4 R5: lanes are only driven while a read is reported
    a_r11_drive_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe != '0) |-> (bus_op == 3'd1));

    // R6 R7: only whole-word or low-byte lane groups
    a_r7_lane_groups: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe == '0) || (dq_oe == '1) || (dq_oe == LOW_LANES));

    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    a_r5_no_strobe_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> $past(hw_rst_n));

    a_r5_reset_reported: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(hw_rst_n, 2) |-> (bus_op == 3'd4));
endmodule

bind pflash_bus_front pflash_bus_front_chk #(.DQ_W(DQ_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_rst_n  (hw_rst_n),
    .dq_oe     (dq_oe),
    .bus_op    (bus_op),
    .cmd_valid (cmd_valid)
);

// File: tb/tb_pflash_bus_front.sv
`timescale 1ns/1ps
module tb_pflash_bus_front;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ce_n, oe_n, we_n, hw_rst_n, word_sel, wprot_n;
    logic [18:0] addr;
    logic [15:0] dq_in;
    logic [7:0]  sect_lock;
    logic [15:0] dq_out, dq_oe;
    logic [2:0]  bus_op;
    logic        cmd_valid;
    logic [19:0] cmd_addr;
    logic [15:0] cmd_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pflash_bus_front dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .hw_rst_n(hw_rst_n), .word_sel(word_sel), .wprot_n(wprot_n),
        .addr(addr), .dq_in(dq_in), .sect_lock(sect_lock),
        .dq_out(dq_out), .dq_oe(dq_oe), .bus_op(bus_op),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
    );

    function automatic logic [15:0] arr_word(input logic [18:0] a);
        logic [7:0] lo = a[7:0];
        return {lo ^ 8'hC3, lo};
    endfunction

    function automatic logic [2:0] exp_op(input logic c, o, w, r);
        if (!r) return 3'd4;
        if (c) return 3'd0;
        if (!o && w) return 3'd1;
        if (o && !w) return 3'd2;
        return 3'd3;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic c, o, w, r, ws, input logic [18:0] a, input logic [15:0] d);
        ce_n = c; oe_n = o; we_n = w; hw_rst_n = r; word_sel = ws; addr = a; dq_in = d;
    endtask

    // Check read-side outputs against the truth table model
    task automatic check_bus(input string req);
        logic [2:0]  eo = exp_op(ce_n, oe_n, we_n, hw_rst_n);
        logic [15:0] w  = arr_word(addr);
        logic [15:0] eoe = 16'h0000;
        logic [15:0] eout = 16'h0000;
        if (eo == 3'd1) begin
            if (word_sel) begin eoe = 16'hFFFF; eout = w; end
            else begin
                eoe  = 16'h00FF;
                eout = {8'h00, dq_in[15] ? w[15:8] : w[7:0]};
            end
        end
        chk({req, " R11 op"}, {29'd0, bus_op}, {29'd0, eo});
        chk({req, " oe"}, {16'd0, dq_oe}, {16'd0, eoe});
        if (eo == 3'd1) chk({req, " data"}, {16'd0, dq_out}, {16'd0, eout});
    endtask

    // One write cycle; end_by_ce selects which strobe rises
    task automatic write_cycle(input string req, input logic ws, input logic [18:0] a,
                               input logic [15:0] d, input bit end_by_ce, input bit expect_ok);
        logic [19:0] ea = ws ? {a, 1'b0} : {a, d[15]};
        logic [15:0] ed = ws ? d : {8'h00, d[7:0]};
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b0, 1'b1, ws, a, d);
        settle();
        chk({req, " R2 write op"}, {29'd0, bus_op}, 32'd2);
        chk({req, " no early strobe"}, {31'd0, cmd_valid}, 32'd0);
        if (end_by_ce) ce_n = 1'b1; else we_n = 1'b1;
        settle();
        chk({req, " strobe"}, {31'd0, cmd_valid}, {31'd0, expect_ok});
        if (expect_ok) begin
            chk({req, " addr"}, {12'd0, cmd_addr}, {12'd0, ea});
            chk({req, " data"}, {16'd0, cmd_data}, {16'd0, ed});
        end
        @(negedge clk);
        chk({req, " R2 one cycle"}, {31'd0, cmd_valid}, 32'd0);
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 19'd0, 16'd0);
    endtask

    initial begin
        #(5ns * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 19'd0, 16'd0);
        wprot_n = 1'b1;
        sect_lock = 8'h00;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("reset op R3", {29'd0, bus_op}, 32'd0);
        chk("reset oe R3", {16'd0, dq_oe}, 32'd0);
        chk("reset strobe R2", {31'd0, cmd_valid}, 32'd0);
        rst_n = 1'b1;

        // R8 R1 R6: read straight after reset, word mode
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 19'h00A5, 16'd0);
        settle();
        check_bus("R8 R1 R6 first read");
        chk("R1 word value", {16'd0, dq_out}, {16'd0, 16'h66A5});

        // R7 byte mode both halves
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 19'h0013, 16'h0000);
        settle();
        check_bus("R7 byte low");
        @(negedge clk);
        dq_in = 16'h8000;
        settle();
        check_bus("R7 byte high");
        chk("R7 high byte value", {16'd0, dq_out}, {16'd0, 16'h00D0});

        // R4 all enables low
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 19'h0001, 16'h1234);
        settle();
        check_bus("R4 all low");
        repeat (3) begin
            @(negedge clk);
            chk("R4 all low no strobe", {31'd0, cmd_valid}, 32'd0);
        end
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 19'h0001, 16'h1234);
        settle();
        check_bus("R4 output disable");
        chk("R4 no strobe after all-low exit", {31'd0, cmd_valid}, 32'd0);

        // R2 writes, word and byte, ended by WE and by CE
        write_cycle("R2 word we", 1'b1, 19'h3_1234, 16'hBEEF, 1'b0, 1'b1);
        write_cycle("R2 word ce", 1'b1, 19'h2_0F0F, 16'h1357, 1'b1, 1'b1);
        write_cycle("R7 byte write", 1'b0, 19'h4_00AA, 16'h80C4, 1'b0, 1'b1);
        write_cycle("R7 byte write lsb0", 1'b0, 19'h4_00AB, 16'h0077, 1'b1, 1'b1);

        // R9 write-protect on boot sectors
        wprot_n = 1'b0;
        write_cycle("R9 wp sector0", 1'b1, 19'h0_0100, 16'h00A0, 1'b0, 1'b0);
        write_cycle("R9 wp sector1", 1'b1, 19'h1_0100, 16'h00A1, 1'b0, 1'b0);
        write_cycle("R9 wp sector2 ok", 1'b1, 19'h2_0100, 16'h00A2, 1'b0, 1'b1);
        wprot_n = 1'b1;
        write_cycle("R9 no wp sector0 ok", 1'b1, 19'h0_0100, 16'h00A0, 1'b0, 1'b1);

        // R10 sector lock flags
        sect_lock = 8'h80;
        write_cycle("R10 locked sector7", 1'b1, 19'h7_0001, 16'h5555, 1'b0, 1'b0);
        write_cycle("R10 unlocked sector6", 1'b1, 19'h6_0001, 16'h5555, 1'b0, 1'b1);
        sect_lock = 8'h00;

        // R5 reset pin during a write
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 19'h3_0000, 16'hCAFE);
        settle();
        drive(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 19'h3_0000, 16'hCAFE);
        settle();
        check_bus("R5 reset pin");
        chk("R5 aborted write", {31'd0, cmd_valid}, 32'd0);
        @(negedge clk);
        chk("R5 aborted write later", {31'd0, cmd_valid}, 32'd0);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 19'h0010, 16'h0000);
        settle();
        check_bus("R5 reset beats read");
        @(negedge clk);
        hw_rst_n = 1'b1;
        settle();
        check_bus("R8 read after hw reset");

        // Random truth-table sweep (R1 R3 R4 R5 R6 R7 R11)
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            drive(1'($urandom), 1'($urandom), 1'($urandom),
                  (($urandom % 8) != 0), 1'($urandom),
                  19'($urandom), 16'($urandom));
            settle();
            check_bus("R3 R4 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule